// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a free-running cycle counter paired with a compare register, the kind a processor core uses for its cycle-tick and system-tick timers. The count advances on each enabled clock; one bit position of the count word (bit 63 by default) is not count data but a control flag that marks the counter as protected from unprivileged reads. Software writes the count, reads it back with that flag folded in, and writes a limit whose flag bit in the same position disables the compare interrupt.

When a limit with a nonzero value and a clear disable flag is written, the compare is armed. On the first cycle that the count equals the limit, the block sets one chosen bit of a software-interrupt register and disarms. The register bit stays set until software pulses the matching bit of a clear strobe. The flag position and the software-interrupt bit are parameters, so the same block serves the cycle-tick instance (which sets the timer bit) and the system-tick instances (which set the system-timer bit). The counter is nominally clocked, or enabled, at a 100 MHz rate.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count reads 0 with the flag bit clear, no compare is armed and every software-interrupt bit is 0.
- R2: With tick_en_i high and no count write, the count read back rises by 1 per clock; with tick_en_i low it holds. The flag bit position never counts: from all data bits set, the next increment gives 0 in the data bits.
- R3: A count write loads every bit except the flag bit (FLAG_BIT, default 63) into the counter and stores the written flag bit as the protect flag, visible on the next cycle; a count write wins over an increment in the same cycle.
- R4: The count read returns the running count, with bit FLAG_BIT set when the protect flag is 1 and clear when it is 0.
- R5: A limit write takes every bit except the flag bit as the compare value; a compare value of 0 is never armed and never sets an interrupt.
- R6: A limit write with the flag bit set disables the compare: it cancels any earlier armed compare and no interrupt follows.
- R7: While armed, in the cycle the count equals the compare value, software-interrupt bit SI_BIT is set on the following clock edge.
- R8: A match fires at most once: it disarms the compare, and only a new enabling limit write, or a wrap of the counter to 0 while the limit is nonzero and enabled, arms it again; a limit write in the same cycle as a match takes effect.
- R9: A software-interrupt bit that is set stays set until a cycle with the same bit of softint_clr_i high clears it; a match in that cycle keeps it set; clearing other bits leaves it untouched, and bits other than SI_BIT stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Count enable, one increment per clock while high |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Count write value; bit FLAG_BIT is the protect flag |
| cnt_rdata_o | output | CNT_W | Count read value with the protect flag in bit FLAG_BIT |
| lim_wr_i | input | 1 | Limit write strobe |
| lim_wdata_i | input | CNT_W | Limit write value; bit FLAG_BIT is the interrupt disable |
| softint_clr_i | input | SI_W | Per-bit clear strobe for the software-interrupt register |
| softint_o | output | SI_W | Software-interrupt register |

## Verification
The bench builds two copies: one with the default 64-bit count, flag bit 63 and interrupt bit 0, as the cycle-tick timer uses it, and one with an 8-bit count, flag bit 7 and interrupt bit 16, standing in for a system-tick timer. The narrow copy wraps every 128 cycles, which brings the wrap, the flag-bit carry skip and the re-arm on wrap within a short run, while the wide copy exercises the full-width flag handling and the placement of bit 63. Both copies run the same random mix of count writes, limit writes near the running count and clear strobes against a cycle model.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Source of the next value of the compare armed state, in priority order.
  typedef enum logic [1:0] {
    ARM_KEEP = 2'd0,
    ARM_LOAD = 2'd1,
    ARM_WRAP = 2'd2,
    ARM_FIRE = 2'd3
  } arm_src_e;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned FLAG_BIT = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             prot_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] FLAG_MASK = CNT_W'(1) << FLAG_BIT;
  localparam logic [CNT_W-1:0] ALL_ONES  = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             prot_q;
  logic             full;

  // Forcing the flag position to 1 lets the carry skip over it.
  assign cnt_inc = ((cnt_q | FLAG_MASK) + CNT_W'(1)) & ~FLAG_MASK;
  assign full    = (cnt_q | FLAG_MASK) == ALL_ONES;
  assign wrap_o  = tick_en_i && !wr_i && full;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)           cnt_d = wdata_i & ~FLAG_MASK;
    else if (tick_en_i) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prot_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_i) prot_q <= wdata_i[FLAG_BIT];
    end
  end

  assign cnt_o  = cnt_q;
  assign prot_o = prot_q;

  // R2: idle cycles leave the count alone
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i && !wr_i |=> $stable(cnt_q));

  // R3: a write lands on the next edge, flag split off
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == ($past(wdata_i) & ~FLAG_MASK)) && (prot_q == $past(wdata_i[FLAG_BIT])));

  // R2: the flag position never holds count data
  a_r2_flag_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i |=> !cnt_q[FLAG_BIT]);
endmodule

// File: rtl/tick_compare.sv
module tick_compare
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned FLAG_BIT = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] FLAG_MASK = CNT_W'(1) << FLAG_BIT;

  logic [CNT_W-1:0] lim_q, lim_new;
  logic             int_dis_q;
  logic             armed_q, armed_d;
  arm_src_e         arm_src;

  assign lim_new = wdata_i & ~FLAG_MASK;
  assign match_o = armed_q && (cnt_i == lim_q);

  always_comb begin
    if (wr_i)         arm_src = ARM_LOAD;
    else if (wrap_i)  arm_src = ARM_WRAP;
    else if (match_o) arm_src = ARM_FIRE;
    else              arm_src = ARM_KEEP;
  end

  always_comb begin
    unique case (arm_src)
      ARM_LOAD: armed_d = (lim_new != '0) && !wdata_i[FLAG_BIT];
      ARM_WRAP: armed_d = (lim_q != '0) && !int_dis_q;
      ARM_FIRE: armed_d = 1'b0;
      default:  armed_d = armed_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q     <= '0;
      int_dis_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (wr_i) begin
        lim_q     <= lim_new;
        int_dis_q <= wdata_i[FLAG_BIT];
      end
    end
  end

  // R5: a zero compare value is never armed
  a_r5_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_q == '0) |-> !armed_q);

  // R6: a disabled limit is never armed
  a_r6_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_dis_q |-> !armed_q);

  // R8: one fire per arming
  a_r8_fire_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o && !wr_i && !wrap_i |=> !match_o);
endmodule

// File: rtl/tick_softint.sv
module tick_softint #(
  parameter int unsigned SI_W   = 17,
  parameter int unsigned SI_BIT = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [SI_W-1:0] clr_i,
  output logic [SI_W-1:0] softint_o
);
  for (genvar k = 0; k < SI_W; k++) begin : g_bit
    if (k == SI_BIT) begin : g_timer
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= set_i | (bit_q & ~clr_i[k]);
      end
      assign softint_o[k] = bit_q;

      // R7: a match sets the bit on the next edge
      a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> bit_q);

      // R9: without set or clear the bit holds
      a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !set_i && !clr_i[k] |=> $stable(bit_q));
    end else begin : g_other
      assign softint_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned FLAG_BIT = CNT_W - 1,
  parameter int unsigned SI_W     = 17,
  parameter int unsigned SI_BIT   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_rdata_o,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  input  logic [SI_W-1:0]  softint_clr_i,
  output logic [SI_W-1:0]  softint_o
);
  localparam logic [CNT_W-1:0] FLAG_MASK = CNT_W'(1) << FLAG_BIT;

  logic [CNT_W-1:0] cnt;
  logic             prot;
  logic             wrap;
  logic             match;

  tick_counter #(.CNT_W(CNT_W), .FLAG_BIT(FLAG_BIT)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .wr_i      (cnt_wr_i),
    .wdata_i   (cnt_wdata_i),
    .cnt_o     (cnt),
    .prot_o    (prot),
    .wrap_o    (wrap)
  );

  tick_compare #(.CNT_W(CNT_W), .FLAG_BIT(FLAG_BIT)) i_compare (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (lim_wr_i),
    .wdata_i (lim_wdata_i),
    .cnt_i   (cnt),
    .wrap_i  (wrap),
    .match_o (match)
  );

  tick_softint #(.SI_W(SI_W), .SI_BIT(SI_BIT)) i_softint (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (match),
    .clr_i     (softint_clr_i),
    .softint_o (softint_o)
  );

  assign cnt_rdata_o = prot ? (cnt | FLAG_MASK) : cnt;

  // R4: the read flag follows the last written count flag
  a_r4_read_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_rdata_o[FLAG_BIT] == $past(cnt_wdata_i[FLAG_BIT]));
endmodule

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;
  localparam int CLK_P = 10;
  localparam int WA = 64, FA = 63, SA = 0;
  localparam int WB = 8,  FB = 7,  SB = 16;
  localparam int SI_W = 17;

  typedef struct packed {
    logic [63:0]     cnt;
    logic [63:0]     lim;
    logic            prot;
    logic            idis;
    logic            arm;
    logic [SI_W-1:0] si;
  } mst_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic            a_tick = 0, a_cwr = 0, a_lwr = 0;
  logic [WA-1:0]   a_cwd = '0, a_lwd = '0, a_rd;
  logic [SI_W-1:0] a_clr = '0, a_si;
  logic            b_tick = 0, b_cwr = 0, b_lwr = 0;
  logic [WB-1:0]   b_cwd = '0, b_lwd = '0, b_rd;
  logic [SI_W-1:0] b_clr = '0, b_si;

  tick_cmp_timer #(.CNT_W(WA), .FLAG_BIT(FA), .SI_W(SI_W), .SI_BIT(SA)) i_tick_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(a_tick), .cnt_wr_i(a_cwr),
    .cnt_wdata_i(a_cwd), .cnt_rdata_o(a_rd), .lim_wr_i(a_lwr),
    .lim_wdata_i(a_lwd), .softint_clr_i(a_clr), .softint_o(a_si));

  tick_cmp_timer #(.CNT_W(WB), .FLAG_BIT(FB), .SI_W(SI_W), .SI_BIT(SB)) i_tick_cmp_timer_sm (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(b_tick), .cnt_wr_i(b_cwr),
    .cnt_wdata_i(b_cwd), .cnt_rdata_o(b_rd), .lim_wr_i(b_lwr),
    .lim_wdata_i(b_lwd), .softint_clr_i(b_clr), .softint_o(b_si));

  int n_chk = 0, n_fail = 0;
  bit done = 0, bg_on = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] f_read(mst_t s, int flag_bit);
    return s.prot ? (s.cnt | (64'd1 << flag_bit)) : s.cnt;
  endfunction

  // Cycle model built from R2..R9.
  function automatic mst_t f_step(mst_t s, logic tick, logic cwr, logic [63:0] cwd,
                                  logic lwr, logic [63:0] lwd, logic [SI_W-1:0] clr,
                                  int width, int flag_bit, int si_bit);
    mst_t n = s;
    logic [63:0] dmask = (width == 64) ? '1 : ((64'd1 << width) - 1);
    logic [63:0] fm = 64'd1 << flag_bit;
    logic [63:0] dbits = dmask & ~fm;
    logic match = s.arm && (s.cnt == s.lim);
    logic wrap = tick && !cwr && (s.cnt == dbits);
    if (cwr) begin
      n.cnt = cwd & dbits;
      n.prot = cwd[flag_bit];
    end else if (tick) begin
      n.cnt = wrap ? 64'd0 : ((s.cnt | fm) + 64'd1) & dbits;
    end
    if (lwr) begin
      n.lim = lwd & dbits;
      n.idis = lwd[flag_bit];
      n.arm = ((lwd & dbits) != 0) && !lwd[flag_bit];
    end else if (wrap) begin
      n.arm = (s.lim != 0) && !s.idis;
    end else if (match) begin
      n.arm = 1'b0;
    end
    n.si = s.si & ~clr;
    if (match) n.si[si_bit] = 1'b1;
    return n;
  endfunction

  mst_t ma, mb;
  always @(posedge clk) begin
    if (!rst_n) begin
      ma <= '0;
      mb <= '0;
    end else begin
      ma <= f_step(ma, a_tick, a_cwr, a_cwd, a_lwr, a_lwd, a_clr, WA, FA, SA);
      mb <= f_step(mb, b_tick, b_cwr, 64'(b_cwd), b_lwr, 64'(b_lwd), b_clr, WB, FB, SB);
    end
  end

  // Background comparison against the model on every falling edge.
  always @(negedge clk) begin
    if (bg_on && rst_n) begin
      check("R4 count read (wide)", 64'(a_rd), f_read(ma, FA));
      check("R7 softint (wide)", 64'(a_si), 64'(ma.si));
      check("R4 count read (narrow)", 64'(b_rd), f_read(mb, FB));
      check("R7 softint (narrow)", 64'(b_si), 64'(mb.si));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic a_wcnt(logic [63:0] v);
    a_cwr = 1; a_cwd = v; cyc(1); a_cwr = 0;
  endtask

  task automatic a_wlim(logic [63:0] v);
    a_lwr = 1; a_lwd = v; cyc(1); a_lwr = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    cyc(3);
    rst_n = 1;
    cyc(2);
    bg_on = 1;
    // R1: reset state
    check("R1 count", a_rd, 64'd0);
    check("R1 softint", 64'(a_si), 64'd0);
    check("R1 narrow count", 64'(b_rd), 64'd0);
    // R3/R4: count write with and without flag
    a_wcnt(64'h8000_0000_0000_0007);
    check("R4 flag read", a_rd, 64'h8000_0000_0000_0007);
    a_tick = 1; cyc(3); a_tick = 0;
    check("R4 flag persists", a_rd, 64'h8000_0000_0000_000A);
    a_wcnt(64'd5);
    check("R3 flag cleared", a_rd, 64'd5);
    // R2: increments while enabled, holds otherwise
    a_tick = 1; cyc(10); a_tick = 0;
    check("R2 ten ticks", a_rd, 64'd15);
    cyc(4);
    check("R2 hold", a_rd, 64'd15);
    // R3: write wins over increment
    a_tick = 1; a_wcnt(64'd100); a_tick = 0;
    check("R3 write priority", a_rd, 64'd100);
    // R7: match sets bit SA one edge after count equals limit
    a_wcnt(64'h10);
    a_wlim(64'h20);
    a_wcnt(64'h20);
    check("R7 not yet", 64'(a_si), 64'd0);
    cyc(1);
    check("R7 fired", 64'(a_si[SA]), 64'd1);
    // R9: holds, survives foreign clear, cleared by own bit
    cyc(5);
    check("R9 held", 64'(a_si[SA]), 64'd1);
    a_clr = 17'h8; cyc(1); a_clr = '0;
    check("R9 other clear", 64'(a_si[SA]), 64'd1);
    a_clr[SA] = 1'b1; cyc(1); a_clr = '0;
    check("R9 own clear", 64'(a_si), 64'd0);
    // R8: no second fire without re-arm
    a_wcnt(64'h1f); a_wcnt(64'h20); cyc(3);
    check("R8 single fire", 64'(a_si), 64'd0);
    // R8: limit write re-arms
    a_wlim(64'h20);
    check("R8 rearm pending", 64'(a_si), 64'd0);
    cyc(1);
    check("R8 rearm fired", 64'(a_si[SA]), 64'd1);
    a_clr[SA] = 1'b1; cyc(1); a_clr = '0;
    // R6: disabled limit never fires and cancels an armed one
    a_wlim(64'h8000_0000_0000_0030);
    a_wcnt(64'h30); cyc(3);
    check("R6 disabled", 64'(a_si), 64'd0);
    a_wlim(64'h40);
    a_wlim(64'h8000_0000_0000_0040);
    a_wcnt(64'h40); cyc(3);
    check("R6 cancelled", 64'(a_si), 64'd0);
    // R5: zero limit never fires
    a_wlim(64'd0);
    a_wcnt(64'd0); cyc(3);
    check("R5 zero limit", 64'(a_si), 64'd0);
    // R2: narrow wrap, flag skipped by the carry
    b_cwr = 1; b_cwd = 8'h7f; cyc(1); b_cwr = 0;
    b_tick = 1; cyc(1); b_tick = 0;
    check("R2 wrap", 64'(b_rd), 64'd0);
    b_cwr = 1; b_cwd = 8'hff; cyc(1); b_cwr = 0;
    b_tick = 1; cyc(1); b_tick = 0;
    check("R2 wrap keeps flag", 64'(b_rd), 64'h80);
    // R8: wrap re-arms
    b_lwr = 1; b_lwd = 8'd5; cyc(1); b_lwr = 0;
    b_cwr = 1; b_cwd = 8'd4; cyc(1); b_cwr = 0;
    b_tick = 1; cyc(4);
    check("R7 narrow fired", 64'(b_si[SB]), 64'd1);
    b_clr[SB] = 1'b1; cyc(1); b_clr = '0;
    cyc(80);
    check("R8 no fire before wrap", 64'(b_si), 64'd0);
    cyc(60);
    check("R8 wrap refire", 64'(b_si[SB]), 64'd1);
    b_tick = 0;
    // Random mix, checked by the background model
    for (int i = 0; i < 4000; i++) begin
      a_tick = ($urandom % 10) < 8;
      a_cwr  = ($urandom % 20) == 0;
      a_cwd  = {1'($urandom % 5 == 0), 57'd0, 6'($urandom)};
      a_lwr  = ($urandom % 20) == 0;
      a_lwd  = {1'($urandom % 5 == 0), 57'd0, 6'($urandom)};
      a_clr  = ($urandom % 8) == 0 ? SI_W'($urandom) : '0;
      b_tick = ($urandom % 10) < 8;
      b_cwr  = ($urandom % 25) == 0;
      b_cwd  = 8'($urandom);
      b_lwr  = ($urandom % 25) == 0;
      b_lwd  = {1'($urandom % 5 == 0), 7'($urandom)};
      b_clr  = ($urandom % 8) == 0 ? SI_W'($urandom) : '0;
      cyc(1);
    end
    a_tick = 0; a_cwr = 0; a_lwr = 0; a_clr = '0;
    b_tick = 0; b_cwr = 0; b_lwr = 0; b_clr = '0;
    cyc(2);
    done = 1;
    summary();
    $finish;
  end
endmodule